// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a register-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and each bank has its own register set. Software chooses the direction of each pin. It changes driven levels only through separate set and clear strobes, and it reads back the synchronized pin levels whatever the direction. It can also arm rising and falling edge capture per pin.

Captured edges sit in sticky status bits until software writes ones to clear them. Status gated by a per-bank interrupt mask drives one combined interrupt line. Pins 0 and 1 also have dedicated interrupt outputs. Bank register blocks are interleaved in groups of three, so three banks share each 256-byte page at 4-byte spacing.

The bus is a plain synchronous register port. A write is taken on the clock edge where `bus_we` is high. Read data is registered: the value for the address presented before an edge appears on `bus_rdata` after that edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank n's register block starts at byte address ((n/3)*256) + ((n%3)*4). Within the block the offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48, interrupt mask 0x9C. Any other address reads 0 and writes to it are ignored.
- R2: After reset, output values, edge enables, status and mask are 0. Each direction bit resets to the inverted-polarity value of its pin, so every pin starts as an input (pin_oe all 0). All interrupt outputs are low.
- R3: A write to the set register drives high each output bit written as 1. A write to the clear register drives low each output bit written as 1. Bits written as 0 keep their value. Both registers read back the current output values.
- R4: The level register returns the pin inputs after a two-flop synchronizer, regardless of direction. A pin change driven just after edge P0 is first returned by a read sampled at edge P3.
- R5: pin_oe equals the direction bit XOR the pin's INV_DIR bit. Direction 1 means output on a normal pin, and direction 0 means output on an inverted pin.
- R6: A status bit is set when its synchronized pin goes low to high with rising enable set, or high to low with falling enable set. Both edges are captured when both enables are set. No capture happens when the matching enable is clear.
- R7: Writing 1 to a status bit clears it. Bits written as 0 are unaffected, and writing all ones clears the whole bank's status.
- R8: When a new edge on a pin and a write-one-to-clear of the same status bit land on the same clock edge, the bit stays set.
- R9: The mask gates only interrupts. Status still captures edges on masked pins, but a masked status bit does not raise any interrupt.
- R10: irq_mux is the OR over all banks of (status AND mask). It stays high until software clears the status or the mask.
- R11: irq_pin0 and irq_pin1 equal bank 0's status AND mask for bit 0 and bit 1 respectively.
- R12: Writes to the level register have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NBANKS*32 | Pin input levels (asynchronous) |
| pin_out | output | NBANKS*32 | Pin output values |
| pin_oe | output | NBANKS*32 | Pin output enables |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |
| irq_mux | output | 1 | Combined interrupt for all pins |

## Verification
The assertions check on every cycle that status bits in bank 0 only fall on a write to its status address, and that bank 0's set and clear strobes take effect on the next cycle. They also check that a level-register write leaves the outputs unchanged, that the combined interrupt holds with no bus write, and that the dedicated pin interrupts agree with status and mask. Only the bench's scenarios can show the interleaved address map and the exact synchronizer latency. The same applies to the rule that a simultaneous edge beats a clear, and to edge capture on masked pins. A reference model compares every register readback and output port during random writes and pin toggles.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int WORD_W     = 32;
    localparam int BANK_IDX_W = 3;
    localparam int NREG       = 8;

    typedef enum logic [2:0] {
        R_LEVEL = 3'd0,
        R_DIR   = 3'd1,
        R_SET   = 3'd2,
        R_CLR   = 3'd3,
        R_RISE  = 3'd4,
        R_FALL  = 3'd5,
        R_STAT  = 3'd6,
        R_MASK  = 3'd7
    } reg_e;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] bank;
        reg_e                  sel;
    } acc_t;

    function automatic int reg_off(reg_e r);
        case (r)
            R_LEVEL: return 'h00;
            R_DIR:   return 'h0C;
            R_SET:   return 'h18;
            R_CLR:   return 'h24;
            R_RISE:  return 'h30;
            R_FALL:  return 'h3C;
            R_STAT:  return 'h48;
            default: return 'h9C;
        endcase
    endfunction

    function automatic int bank_base(int n);
        return ((n / 3) << 8) + ((n % 3) << 2);
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int NBANKS = 7,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    always_comb begin
        acc = '0;
        for (int b = 0; b < NBANKS; b++) begin
            for (int r = 0; r < NREG; r++) begin
                if (addr == ADDR_W'(bank_base(b) + reg_off(reg_e'(r[2:0])))) begin
                    acc.hit  = 1'b1;
                    acc.bank = BANK_IDX_W'(b);
                    acc.sel  = reg_e'(r[2:0]);
                end
            end
        end
    end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter logic [WORD_W-1:0] INV = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_e              sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] pin_s,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] out_val,
    output logic [WORD_W-1:0] out_en,
    output logic [WORD_W-1:0] stat,
    output logic [WORD_W-1:0] mask,
    output logic              irq_any
);
    logic [WORD_W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, mask_q, prev_q;
    logic [WORD_W-1:0] edge_hit, clr_bits, stat_nxt;

    assign edge_hit = (pin_s & ~prev_q & rise_q) | (~pin_s & prev_q & fall_q);
    assign clr_bits = (wr_en && sel == R_STAT) ? wr_data : '0;
    assign stat_nxt = (stat_q & ~clr_bits) | edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= INV;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
            mask_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pin_s;
            stat_q <= stat_nxt;
            if (wr_en) begin
                case (sel)
                    R_DIR:   dir_q  <= wr_data;
                    R_SET:   out_q  <= out_q | wr_data;
                    R_CLR:   out_q  <= out_q & ~wr_data;
                    R_RISE:  rise_q <= wr_data;
                    R_FALL:  fall_q <= wr_data;
                    R_MASK:  mask_q <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            R_LEVEL:      rd_data = pin_s;
            R_DIR:        rd_data = dir_q;
            R_SET, R_CLR: rd_data = out_q;
            R_RISE:       rd_data = rise_q;
            R_FALL:       rd_data = fall_q;
            R_STAT:       rd_data = stat_q;
            default:      rd_data = mask_q;
        endcase
    end

    assign out_val = out_q;
    assign out_en  = dir_q ^ INV;
    assign stat    = stat_q;
    assign mask    = mask_q;
    assign irq_any = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpb_pkg::*;
#(
    parameter int NBANKS = 7,
    parameter int ADDR_W = 12,
    parameter logic [NBANKS*32-1:0] INV_DIR = (NBANKS*32)'(4'hF) << 86
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NBANKS*32-1:0]   pin_in,
    output logic [NBANKS*32-1:0]   pin_out,
    output logic [NBANKS*32-1:0]   pin_oe,
    output logic                   irq_pin0,
    output logic                   irq_pin1,
    output logic                   irq_mux
);
    localparam int NPINS = NBANKS * WORD_W;

    logic [NPINS-1:0]  pin_s;
    logic [NPINS-1:0]  stat_flat;
    logic [NPINS-1:0]  mask_flat;
    logic [NBANKS-1:0] bank_irq;
    logic [NBANKS-1:0] bank_we;
    logic [WORD_W-1:0] bank_rd [NBANKS];
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] rdata_q;
    acc_t              acc;

    gpb_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    gpb_decode #(.NBANKS(NBANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign bank_we[b] = bus_we && acc.hit && (acc.bank == BANK_IDX_W'(b));

        gpb_bank #(.INV(INV_DIR[b*WORD_W +: WORD_W])) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_we[b]),
            .sel     (acc.sel),
            .wr_data (bus_wdata),
            .pin_s   (pin_s[b*WORD_W +: WORD_W]),
            .rd_data (bank_rd[b]),
            .out_val (pin_out[b*WORD_W +: WORD_W]),
            .out_en  (pin_oe[b*WORD_W +: WORD_W]),
            .stat    (stat_flat[b*WORD_W +: WORD_W]),
            .mask    (mask_flat[b*WORD_W +: WORD_W]),
            .irq_any (bank_irq[b])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (acc.hit && acc.bank == BANK_IDX_W'(b)) rd_word = bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
    assign irq_mux   = |bank_irq;
    assign irq_pin0  = stat_flat[0] & mask_flat[0];
    assign irq_pin1  = stat_flat[1] & mask_flat[1];
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       out0,
    input logic [31:0]       stat0,
    input logic [1:0]        mask01,
    input logic              irq_pin0,
    input logic              irq_pin1,
    input logic              irq_mux
);
    localparam logic [ADDR_W-1:0] A_LEVEL0 = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] A_SET0   = ADDR_W'(12'h018);
    localparam logic [ADDR_W-1:0] A_CLR0   = ADDR_W'(12'h024);
    localparam logic [ADDR_W-1:0] A_STAT0  = ADDR_W'(12'h048);

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET0) |=> ((out0 & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR0) |=> ((out0 & $past(bus_wdata)) == 32'h0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_STAT0) |=> ((stat0 & $past(stat0)) == $past(stat0)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_mux && !bus_we) |=> irq_mux);

    p_pin0_r11: assert property (@(posedge clk) disable iff (rst)
        irq_pin0 |-> (irq_mux && stat0[0] && mask01[0]));

    p_pin1_r11: assert property (@(posedge clk) disable iff (rst)
        irq_pin1 |-> (irq_mux && stat0[1] && mask01[1]));

    p_level_wr_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_LEVEL0) |=> $stable(out0));
endmodule

bind gpio_bank_ctrl gpb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .out0      (pin_out[31:0]),
    .stat0     (stat_flat[31:0]),
    .mask01    (mask_flat[1:0]),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_mux   (irq_mux)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
    localparam int NB = 7;
    localparam int AW = 12;
    localparam int NP = NB * 32;
    localparam logic [NP-1:0] INV_TB = NP'(4'hF) << 86;

    logic          clk = 0;
    logic          rst = 1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq_pin0, irq_pin1, irq_mux;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pin[NB], m_dir[NB], m_out[NB], m_rise[NB];
    logic [31:0] m_fall[NB], m_stat[NB], m_mask[NB], nxt_pin[NB];

    gpio_bank_ctrl #(.NBANKS(NB), .ADDR_W(AW), .INV_DIR(INV_TB)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_mux(irq_mux)
    );

    always #2 clk = ~clk;

    function automatic int off_of(int r);
        case (r)
            0: return 'h00; 1: return 'h0C; 2: return 'h18; 3: return 'h24;
            4: return 'h30; 5: return 'h3C; 6: return 'h48; default: return 'h9C;
        endcase
    endfunction

    function automatic logic [AW-1:0] addr_of(int b, int r);
        return AW'((b / 3) * 256 + (b % 3) * 4 + off_of(r));
    endfunction

    function automatic logic [31:0] inv_of(int b);
        return INV_TB[b*32 +: 32];
    endfunction

    function automatic logic [31:0] exp_reg(int b, int r);
        case (r)
            0: return m_pin[b]; 1: return m_dir[b]; 2, 3: return m_out[b];
            4: return m_rise[b]; 5: return m_fall[b]; 6: return m_stat[b];
            default: return m_mask[b];
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
        bus_addr = a;
        bus_we   = 0;
        @(posedge clk); #1;
        v = bus_rdata;
    endtask

    task automatic check_reg(int b, int r, string tag);
        logic [31:0] v;
        rd(addr_of(b, r), v);
        chk(tag, v, exp_reg(b, r));
    endtask

    task automatic check_ports(string tag);
        logic any;
        any = 0;
        for (int b = 0; b < NB; b++) begin
            chk({tag, " pin_out"}, pin_out[b*32 +: 32], m_out[b]);
            chk({tag, " pin_oe"}, pin_oe[b*32 +: 32], m_dir[b] ^ inv_of(b));
            any |= |(m_stat[b] & m_mask[b]);
        end
        chk({tag, " irq_mux R10"}, {31'b0, irq_mux}, {31'b0, any});
        chk({tag, " irq_pin0 R11"}, {31'b0, irq_pin0}, {31'b0, m_stat[0][0] & m_mask[0][0]});
        chk({tag, " irq_pin1 R11"}, {31'b0, irq_pin1}, {31'b0, m_stat[0][1] & m_mask[0][1]});
    endtask

    task automatic model_write(int b, int r, logic [31:0] d);
        case (r)
            1: m_dir[b] = d;
            2: m_out[b] = m_out[b] | d;
            3: m_out[b] = m_out[b] & ~d;
            4: m_rise[b] = d;
            5: m_fall[b] = d;
            6: m_stat[b] = m_stat[b] & ~d;
            7: m_mask[b] = d;
            default: ;
        endcase
    endtask

    task automatic wr(int b, int r, logic [31:0] d, string tag);
        bus_addr  = addr_of(b, r);
        bus_wdata = d;
        bus_we    = 1;
        @(posedge clk); #1;
        bus_we = 0;
        model_write(b, r, d);
        check_ports(tag);
    endtask

    task automatic model_edges();
        for (int b = 0; b < NB; b++) begin
            m_stat[b] |= (nxt_pin[b] & ~m_pin[b] & m_rise[b]) |
                         (~nxt_pin[b] & m_pin[b] & m_fall[b]);
            m_pin[b] = nxt_pin[b];
        end
    endtask

    task automatic apply_pins(string tag);
        for (int b = 0; b < NB; b++) pin_in[b*32 +: 32] = nxt_pin[b];
        repeat (4) @(posedge clk);
        #1;
        model_edges();
        check_ports(tag);
    endtask

    task automatic drive_pin(int b, int bit_i, logic v);
        for (int k = 0; k < NB; k++) nxt_pin[k] = m_pin[k];
        nxt_pin[b][bit_i] = v;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < NB; b++) begin
            m_pin[b] = 0; m_dir[b] = inv_of(b); m_out[b] = 0; m_rise[b] = 0;
            m_fall[b] = 0; m_stat[b] = 0; m_mask[b] = 0; nxt_pin[b] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R2: reset state
        check_ports("R2 reset");
        rd(addr_of(2, 1), v); chk("R2 dir reset bank2", v, 32'h03C0_0000);
        check_reg(0, 6, "R2 status reset");
        check_reg(5, 7, "R2 mask reset");

        // R1: interleaved map and unmapped addresses
        wr(3, 7, 32'hA5A5_0001, "R1 wr mask bank3");
        rd(AW'(12'h19C), v); chk("R1 bank3 mask @0x19C", v, 32'hA5A5_0001);
        wr(6, 4, 32'h0000_8001, "R1 wr rise bank6");
        rd(AW'(12'h230), v); chk("R1 bank6 rise @0x230", v, 32'h0000_8001);
        wr(1, 5, 32'h1234_5678, "R1 wr fall bank1");
        rd(AW'(12'h040), v); chk("R1 bank1 fall @0x040", v, 32'h1234_5678);
        rd(AW'(12'h058), v); chk("R1 unmapped 0x058", v, 32'h0);
        rd(AW'(12'h3F0), v); chk("R1 unmapped 0x3F0", v, 32'h0);
        wr(1, 5, 32'h0, "R1 restore");
        wr(6, 4, 32'h0, "R1 restore");
        wr(3, 7, 32'h0, "R1 restore");

        // R3: set / clear strobes
        wr(0, 2, 32'h0000_F0F0, "R3 set");
        wr(0, 3, 32'h0000_00F0, "R3 clear");
        chk("R3 pin_out after set/clear", pin_out[31:0], 32'h0000_F000);
        rd(addr_of(0, 3), v); chk("R3 clear reg reads outputs", v, 32'h0000_F000);

        // R5: direction polarity
        wr(2, 1, 32'hFFFF_FFFF, "R5 dir bank2");
        chk("R5 inverted pins disabled", pin_oe[95:64], 32'hFC3F_FFFF);
        wr(2, 1, 32'h0, "R5 dir bank2 zero");
        chk("R5 inverted pins enabled", pin_oe[95:64], 32'h03C0_0000);

        // R4: synchronizer latency on level readback (bank4 bit7)
        drive_pin(4, 7, 1);
        pin_in[4*32+7] = 1;
        bus_addr = addr_of(4, 0);
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R4 level not yet visible", bus_rdata, 32'h0);
        @(posedge clk); #1;
        chk("R4 level visible at third edge", bus_rdata, 32'h0000_0080);
        @(posedge clk); #1;
        model_edges();

        // R4: output-direction pin still reads its input level
        wr(4, 1, 32'h0000_0080, "R4 make output");
        check_reg(4, 0, "R4 level on output pin");

        // R6: rise only, fall only, both (bank1 bit3)
        wr(1, 4, 32'h0000_0008, "R6 rise en");
        drive_pin(1, 3, 1); apply_pins("R6 rise");
        chk("R6 rising captured", m_stat[1], 32'h8);
        check_reg(1, 6, "R6 rise status");
        wr(1, 6, 32'hFFFF_FFFF, "R7 clear all");
        check_reg(1, 6, "R7 all ones clears bank");
        drive_pin(1, 3, 0); apply_pins("R6 fall no enable");
        check_reg(1, 6, "R6 fall ignored without enable");
        wr(1, 4, 32'h0, "R6 rise off");
        wr(1, 5, 32'h0000_0008, "R6 fall en");
        drive_pin(1, 3, 1); apply_pins("R6 rise no enable");
        check_reg(1, 6, "R6 rise ignored without enable");
        drive_pin(1, 3, 0); apply_pins("R6 fall");
        check_reg(1, 6, "R6 falling captured");
        wr(1, 6, 32'h0, "R7 write zero");
        check_reg(1, 6, "R7 zero bits unaffected");
        wr(1, 6, 32'h0000_0008, "R7 clear bit");
        wr(1, 4, 32'h0000_0008, "R6 both en");
        drive_pin(1, 3, 1); apply_pins("R6 both rise");
        check_reg(1, 6, "R6 both: rise captured");
        wr(1, 6, 32'h0000_0008, "R7 clear bit");
        drive_pin(1, 3, 0); apply_pins("R6 both fall");
        check_reg(1, 6, "R6 both: fall captured");

        // R9/R10: masked capture, then unmask
        check_ports("R9 masked status no irq");
        chk("R9 irq_mux low while masked", {31'b0, irq_mux}, 32'h0);
        wr(1, 7, 32'h0000_0008, "R9 unmask");
        chk("R10 irq_mux high", {31'b0, irq_mux}, 32'h1);
        repeat (5) @(posedge clk);
        #1 chk("R10 irq_mux held", {31'b0, irq_mux}, 32'h1);
        wr(1, 6, 32'h0000_0008, "R10 clear");
        chk("R10 irq_mux released", {31'b0, irq_mux}, 32'h0);

        // R11: dedicated pin interrupts
        wr(0, 4, 32'h0000_0003, "R11 rise en");
        wr(0, 7, 32'h0000_0002, "R11 mask pin1");
        drive_pin(0, 0, 1); apply_pins("R11 pin0 edge");
        drive_pin(0, 1, 1); apply_pins("R11 pin1 edge");
        chk("R11 irq_pin0 masked", {31'b0, irq_pin0}, 32'h0);
        chk("R11 irq_pin1 set", {31'b0, irq_pin1}, 32'h1);
        wr(0, 7, 32'h0000_0003, "R11 mask both");
        chk("R11 irq_pin0 set", {31'b0, irq_pin0}, 32'h1);
        wr(0, 6, 32'h0000_0003, "R11 clear");

        // R8: edge and clear on the same clock edge (bank0 bit5)
        wr(0, 4, 32'h0000_0020, "R8 rise en");
        drive_pin(0, 5, 1); apply_pins("R8 first rise");
        drive_pin(0, 5, 0); apply_pins("R8 fall");
        check_reg(0, 6, "R8 status set before race");
        drive_pin(0, 5, 1);
        pin_in[5] = 1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        bus_addr = addr_of(0, 6); bus_wdata = 32'h0000_0020; bus_we = 1;
        @(posedge clk); #1;
        bus_we = 0;
        model_edges();
        check_reg(0, 6, "R8 edge wins over clear");
        chk("R8 status bit kept", m_stat[0] & 32'h20, 32'h20);

        // R12: write to level register ignored
        wr(0, 0, 32'hFFFF_FFFF, "R12 level write");
        check_reg(0, 0, "R12 level unchanged");
        check_reg(0, 2, "R12 outputs unchanged");

        // Random phase
        for (int i = 0; i < 500; i++) begin
            int op, b, r;
            op = int'($urandom % 4);
            b  = int'($urandom % NB);
            r  = int'($urandom % 8);
            if (op == 0) begin
                wr(b, r, $urandom, "R1 R3 R7 random write");
            end else if (op == 1) begin
                for (int k = 0; k < NB; k++)
                    nxt_pin[k] = m_pin[k] ^ ($urandom & $urandom & $urandom);
                apply_pins("R6 random pins");
            end else begin
                check_reg(b, r, "R1 R4 R6 random read");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule